// File: doc/BRIEF.md
# High-Speed Clock Stop Monitor

This block supervises a high-speed system clock from a free-running internal oscillator clock. Software arms it through a one-way enable bit. Arming takes effect only after the high-speed oscillator has finished a settling period. That period is counted on the high-speed clock itself, and its length is picked by a small select code. Once armed, the block counts internal-clock cycles during which the high-speed clock shows no edge. If a full quiet window passes, the block issues a fixed-length internal reset pulse, sets a sticky reset-cause flag and disarms itself.

After such a reset, the system keeps running from the internal oscillator. The monitor stays idle until software writes the enable bit again. The cause flag survives the internal reset. Only the external reset or a software clear strobe removes it. The high-speed clock is sampled as data in the internal clock domain, so it must hold each level for longer than one internal clock period.

Top module: `osc_stop_monitor`

## Requirements
- R1: While the external reset `rst_n` is low, and right after it is released, `int_rst`, `cause_flag` and `mon_active` are all 0.
- R2: `mon_active` is 1 only when the enable bit is set and the settling count has finished. An enable written during settling takes effect without a further write, within 2 high-speed clock rising edges after the count ends. An enable written after settling takes effect within 3 internal clock cycles.
- R3: The settling length, in high-speed rising edges after reset release, is 2^(E-STAB_DOWN). E is 11, 13, 14 and 15 for `stab_sel` codes 0, 1, 2 and 3. E is 16 for code 4 and for every higher code.
- R4: While `mon_active` is 1, a stretch of WIN (4) internal cycles with no high-speed edge raises `int_rst` and sets `cause_flag` to 1. Detection is never earlier than 4 internal cycles after the clock stops.
- R5: Each `int_rst` pulse lasts exactly RST_LEN (17) internal clock cycles and then releases.
- R6: A stop detection clears the enable bit, so `mon_active` is 0 during and after the pulse. Enable writes made while `int_rst` is 1 are ignored. A later enable write re-arms the block.
- R7: `cause_flag` stays 1 through the internal reset. It clears on a `flag_clr` strobe or on the external reset.
- R8: An enable write with `en_wdata` = 0 does not clear an already set enable bit.
- R9: When the high-speed clock never runs, settling never finishes. `mon_active` then stays 0 and no internal reset is generated, even with the enable bit set.
- R10: An enable write with `en_wdata` = 0 does not set the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Free-running internal oscillator clock |
| clk_hs | input | 1 | Monitored high-speed clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| en_wr | input | 1 | Enable write strobe (internal clock domain) |
| en_wdata | input | 1 | Enable write data; only 1 has an effect |
| flag_clr | input | 1 | Cause-flag clear strobe |
| stab_sel | input | SEL_W | Settling length select code, held static |
| int_rst | output | 1 | Internal reset pulse, active high |
| cause_flag | output | 1 | Sticky flag: reset caused by clock stop |
| mon_active | output | 1 | Monitoring armed and settled |

## Verification
The bench builds the block with STAB_DOWN = 6, which shrinks the settling lengths to 32 through 1024 high-speed edges. This makes every select code, including the codes above 4, reachable in a short run. The quiet window (4) and the pulse length (17) keep their default values, so stop latency and exact pulse length are checked as specified. The high-speed clock half-period is varied at random between 13 and 17 ns, and the bench can halt the high-speed clock from the start or in the middle of a run.

// File: rtl/osc_stop_monitor.sv
module osc_stop_monitor #(
  parameter int WIN       = 4,
  parameter int RST_LEN   = 17,
  parameter int STAB_DOWN = 0,
  parameter int SEL_W     = 3
) (
  input  logic             clk_int,
  input  logic             clk_hs,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             flag_clr,
  input  logic [SEL_W-1:0] stab_sel,
  output logic             int_rst,
  output logic             cause_flag,
  output logic             mon_active
);
  localparam int CW = 17 - STAB_DOWN;
  localparam int IW = $clog2(WIN + 1);
  localparam int RW = $clog2(RST_LEN + 1);

  function automatic logic [CW-1:0] stab_last(input logic [SEL_W-1:0] code);
    int e;
    case (int'(code))
      0:       e = 11;
      1:       e = 13;
      2:       e = 14;
      3:       e = 15;
      default: e = 16;
    endcase
    return CW'((1 << (e - STAB_DOWN)) - 1);
  endfunction

  logic [CW-1:0] stab_cnt;
  logic          stab_done;

  always_ff @(posedge clk_hs or negedge rst_n) begin
    if (!rst_n) begin
      stab_cnt  <= '0;
      stab_done <= 1'b0;
    end else if (!stab_done) begin
      if (stab_cnt == stab_last(stab_sel)) stab_done <= 1'b1;
      else                                 stab_cnt  <= stab_cnt + 1'b1;
    end
  end

  logic [2:0]    hs_sync;
  logic [1:0]    done_sync;
  logic          en;
  logic [IW-1:0] idle;
  logic [RW-1:0] rst_cnt;
  logic          hs_edge, stop_det;

  assign hs_edge    = hs_sync[2] ^ hs_sync[1];
  assign mon_active = en & done_sync[1];
  assign stop_det   = mon_active & ~hs_edge & (idle == IW'(WIN - 1));
  assign int_rst    = (rst_cnt != '0);

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) begin
      hs_sync    <= '0;
      done_sync  <= '0;
      en         <= 1'b0;
      idle       <= '0;
      rst_cnt    <= '0;
      cause_flag <= 1'b0;
    end else begin
      hs_sync   <= {hs_sync[1:0], clk_hs};
      done_sync <= {done_sync[0], stab_done};

      if (!mon_active || hs_edge || stop_det) idle <= '0;
      else if (idle != IW'(WIN))              idle <= idle + 1'b1;

      if (stop_det)     rst_cnt <= RW'(RST_LEN);
      else if (int_rst) rst_cnt <= rst_cnt - 1'b1;

      if (stop_det)                             en <= 1'b0;
      else if (en_wr && en_wdata && !int_rst)   en <= 1'b1;

      if (stop_det)      cause_flag <= 1'b1;
      else if (flag_clr) cause_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/osc_stop_monitor_chk.sv
module osc_stop_monitor_chk #(
  parameter int RST_LEN = 17
) (
  input logic clk_int,
  input logic rst_n,
  input logic flag_clr,
  input logic int_rst,
  input logic cause_flag,
  input logic mon_active
);
  int hi_cnt;

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= 0;
    else if (int_rst) hi_cnt <= hi_cnt + 1;
    else              hi_cnt <= 0;
  end

  a_r4_flag_with_reset: assert property (@(posedge clk_int) disable iff (!rst_n)
    $rose(int_rst) |-> cause_flag);

  a_r5_pulse_bound: assert property (@(posedge clk_int) disable iff (!rst_n)
    hi_cnt <= RST_LEN);

  a_r5_pulse_exact: assert property (@(posedge clk_int) disable iff (!rst_n)
    $fell(int_rst) |-> hi_cnt == RST_LEN);

  a_r6_disarmed_in_reset: assert property (@(posedge clk_int) disable iff (!rst_n)
    int_rst |-> !mon_active);

  a_r7_flag_clear_cause: assert property (@(posedge clk_int) disable iff (!rst_n)
    $fell(cause_flag) |-> $past(flag_clr));

  a_r8_active_falls_on_stop: assert property (@(posedge clk_int) disable iff (!rst_n)
    $fell(mon_active) |-> int_rst);
endmodule

bind osc_stop_monitor osc_stop_monitor_chk #(.RST_LEN(RST_LEN)) i_chk (
  .clk_int(clk_int), .rst_n(rst_n), .flag_clr(flag_clr),
  .int_rst(int_rst), .cause_flag(cause_flag), .mon_active(mon_active));

// File: tb/test_osc_stop_monitor.sv
`timescale 1ns/1ps
module test_osc_stop_monitor;
  localparam int DOWN = 6;
  localparam int RLEN = 17;

  logic clk_int = 0, clk_hs = 0, rst_n = 0;
  logic en_wr = 0, en_wdata = 0, flag_clr = 0;
  logic [2:0] stab_sel = 3'd0;
  logic int_rst, cause_flag, mon_active;

  int vectors = 0, miscompares = 0;
  int hs_half = 13;
  bit hs_run = 1;
  int hs_edges = 0;

  osc_stop_monitor #(.WIN(4), .RST_LEN(RLEN), .STAB_DOWN(DOWN), .SEL_W(3)) i_osc_stop_monitor (
    .clk_int(clk_int), .clk_hs(clk_hs), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .flag_clr(flag_clr), .stab_sel(stab_sel), .int_rst(int_rst), .cause_flag(cause_flag),
    .mon_active(mon_active));

  always #5 clk_int = ~clk_int;

  always begin
    #(hs_half);
    if (hs_run) clk_hs = ~clk_hs;
  end

  always @(posedge clk_hs or negedge rst_n)
    if (!rst_n) hs_edges <= 0;
    else        hs_edges <= hs_edges + 1;

  function automatic int exp_limit(input int code);
    int e;
    case (code)
      0: e = 11; 1: e = 13; 2: e = 14; 3: e = 15;
      default: e = 16;
    endcase
    return 1 << (e - DOWN);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_int);
  endtask

  task automatic do_reset();
    @(negedge clk_int);
    rst_n = 0; en_wr = 0; en_wdata = 0; flag_clr = 0;
    cyc(3);
    chk(int_rst == 0,    "R1 int_rst in reset", int_rst, 0);
    chk(cause_flag == 0, "R1/R7 flag cleared by reset", cause_flag, 0);
    chk(mon_active == 0, "R1 active in reset", mon_active, 0);
    rst_n = 1;
    cyc(1);
    chk(int_rst == 0 && cause_flag == 0 && mon_active == 0, "R1 after release",
        {int_rst, cause_flag, mon_active}, 0);
  endtask

  task automatic pulse_en(input bit d);
    en_wr = 1; en_wdata = d;
    cyc(1);
    en_wr = 0; en_wdata = 0;
  endtask

  task automatic trial(input int code, input bit clear_flag);
    int lim, n, e, len;
    bit seen, act_seen;
    stab_sel = 3'(code);
    hs_half = 13 + $urandom_range(0, 4);
    hs_run = 1;
    do_reset();
    lim = exp_limit(code);
    cyc($urandom_range(1, 20));
    pulse_en(1);
    chk(mon_active == 0, "R2 enable deferred during settling", mon_active, 0);
    n = 0;
    while (!mon_active && n < lim * 8) begin cyc(1); n++; end
    e = hs_edges;
    chk(mon_active == 1, "R2 arms after settling", mon_active, 1);
    chk(e >= lim && e <= lim + 2, "R3 settling length", e, lim);
    pulse_en(0);
    cyc(3);
    chk(mon_active == 1, "R8 zero write keeps enable", mon_active, 1);
    cyc($urandom_range(5, 40));
    hs_run = 0;
    seen = 0;
    for (int i = 0; i < 3; i++) begin cyc(1); if (int_rst) seen = 1; end
    chk(!seen, "R4 no early detection", seen, 0);
    n = 0;
    while (!int_rst && n < 12) begin cyc(1); n++; end
    chk(int_rst == 1,    "R4 stop raises reset", int_rst, 1);
    chk(cause_flag == 1, "R4 stop sets flag", cause_flag, 1);
    len = 0; act_seen = 0;
    while (int_rst && len < 100) begin
      if (mon_active) act_seen = 1;
      if (len == 2) begin en_wr = 1; en_wdata = 1; end
      if (len == 3) begin en_wr = 0; en_wdata = 0; end
      cyc(1);
      len++;
    end
    en_wr = 0; en_wdata = 0;
    chk(len == RLEN, "R5 pulse length", len, RLEN);
    chk(!act_seen, "R6 disarmed during pulse", act_seen, 0);
    hs_run = 1;
    cyc(5);
    chk(mon_active == 0, "R6 write during pulse ignored", mon_active, 0);
    chk(cause_flag == 1, "R7 flag survives internal reset", cause_flag, 1);
    pulse_en(1);
    cyc(3);
    chk(mon_active == 1, "R6 re-enable arms", mon_active, 1);
    if (clear_flag) begin
      flag_clr = 1; cyc(1); flag_clr = 0; cyc(1);
      chk(cause_flag == 0, "R7 clear strobe", cause_flag, 0);
    end
  endtask

  initial begin
    int lim;
    bit any_rst;
    void'($urandom(32'd4321));
    for (int c = 0; c < 8; c++) trial(c, c[0]);
    for (int k = 0; k < 4; k++) trial($urandom_range(0, 7), 1'($urandom_range(0, 1)));

    hs_run = 0;
    stab_sel = 3'd0;
    do_reset();
    pulse_en(1);
    any_rst = 0;
    for (int i = 0; i < 200; i++) begin cyc(1); if (int_rst) any_rst = 1; end
    chk(!any_rst, "R9 no reset without settling", any_rst, 0);
    chk(mon_active == 0, "R9 not armed without settling", mon_active, 0);
    chk(cause_flag == 0, "R9 flag stays clear", cause_flag, 0);

    hs_run = 1;
    do_reset();
    lim = exp_limit(0);
    pulse_en(0);
    cyc(lim * 8);
    chk(mon_active == 0, "R10 zero write does not arm", mon_active, 0);
    pulse_en(1);
    cyc(3);
    chk(mon_active == 1, "R2 late enable arms promptly", mon_active, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1900000;
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule